// File: doc/BRIEF.md
# Latched Alarm Status and Interrupt Register

This block gathers the alarm indications of seven subchannel framers into one 16-bit register that a host can read. Each framer reports two live conditions: loss of frame and an incoming alarm indication signal. For every channel and condition the block keeps a sticky flag. The flag sets while the condition is present. A host read clears it, but only when the condition has already gone away.

Any change of state of a channel's alarm input can raise a pending summary flag and an interrupt request. A change in either direction counts. Two things must allow it: the enable bit for that alarm kind, kept in the register itself, and a master mask supplied from outside. A host read lets the pending interrupt drop. A reduced-channel mode keeps only the first four channels. Flags of the upper channels then read as zero, and their events are ignored. The alarm inputs are asynchronous to the clock, so each one passes through a synchronizer. Its change of state is found by comparing it with its own value from the previous cycle.

Top module: `alarm_status_reg`

## Requirements
- R1: After reset, every bit of the register reads 0, and `sum_stat` and `irq_out` are 0.
- R2: A cycle with `host_wr` high loads `host_wdata[7]` into the loss-of-frame enable (bit 7) and `host_wdata[15]` into the alarm-indication enable (bit 15). All other write data bits have no effect on the read value.
- R3: Channel n (1 to 7) owns two flags. Its loss-of-frame flag is at bit n-1 and is set by `lof_raw[n-1]`. Its alarm-indication flag is at bit n+7 and is set by `ais_raw[n-1]`. A raw input held at 1 makes its flag read 1 exactly SYNC_STAGES+1 clock edges after the input rises.
- R4: Once set, a flag stays 1 until a host read (`host_rd` high for one cycle). The read clears the flag only if the synchronized condition is absent at that edge. If the condition is still present, the flag stays 1.
- R5: If a new change of state and a clearing host read fall on the same edge, the set wins. Both the flag and the pending interrupt stay 1.
- R6: A change of state of an active channel's synchronized input sets `sum_stat` and `irq_out` on the same edge its flag would set. This holds for a rise (0 to 1) and for a fall (1 to 0). It requires the enable bit of that alarm kind to be 1 and `master_mask` to be 1.
- R7: No change of state sets `sum_stat` or `irq_out` while its kind's enable bit is 0 or `master_mask` is 0. An enable for the other kind does not count.
- R8: `irq_out` and `sum_stat` are active-high levels. They stay 1 from the qualifying event until the next host read, and are 0 after that read unless a new event falls on the same edge.
- R9: While `reduced_mode` is 1, channels 5 to 7 read 0 at bits 4 to 6 and 12 to 14. Their changes of state never set `sum_stat` or `irq_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lof_raw | input | 7 | Live loss-of-frame condition per channel, asynchronous |
| ais_raw | input | 7 | Live alarm-indication condition per channel, asynchronous |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_rd | input | 1 | Read strobe, one cycle per read; clears flags and pending interrupt |
| host_wdata | input | 16 | Write data; only bits 7 and 15 are stored |
| host_rdata | output | 16 | Register contents, valid in every cycle |
| reduced_mode | input | 1 | 1 limits operation to channels 1 to 4 |
| master_mask | input | 1 | 1 lets this register's events reach the summary and interrupt |
| sum_stat | output | 1 | Pending summary status |
| irq_out | output | 1 | Active-high interrupt request level |

## Verification
The bench builds the block with its default parameters: seven channels, four channels in reduced mode, and a two-stage synchronizer, so every input change reaches the register after three edges. This small setup makes a full sweep practical. The sweep covers every channel, both alarm kinds, both modes, three enable settings and both states of the master mask, and checks rising and falling changes as well as reads with the condition present and absent. One targeted test places a fresh change of state on the same edge as a clearing read, to confirm that the set wins.

// File: rtl/alarm_stat_pkg.sv
package alarm_stat_pkg;

  localparam int REG_W      = 16;
  localparam int HALF_W     = REG_W / 2;
  localparam int MAX_CH     = HALF_W - 1;
  localparam int KINDS      = 2;

  // Alarm kind index: selects the register half and its enable bit.
  typedef enum logic {
    KIND_LOF = 1'b0,
    KIND_AIS = 1'b1
  } alarm_kind_e;

  // Bit position of the enable for a given kind (7 or 15).
  function automatic int ie_pos(input int kind);
    return kind * HALF_W + MAX_CH;
  endfunction

  // Bit position of a channel flag for a given kind.
  function automatic int flag_pos(input int kind, input int ch);
    return kind * HALF_W + ch;
  endfunction

endpackage

// File: rtl/alarm_sync.sv
module alarm_sync #(
  parameter int W      = 7,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] q_sync
);

  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d_async;
    for (int s = 1; s < STAGES; s++) begin
      stg_d[s] = stg_q[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= '0;
      end
    end else begin
      for (int s = 0; s < STAGES; s++) begin
        stg_q[s] <= stg_d[s];
      end
    end
  end

  assign q_sync = stg_q[STAGES-1];

endmodule

// File: rtl/alarm_latch_bank.sv
module alarm_latch_bank #(
  parameter int NCH         = 7,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] raw,
  input  logic           rd_clr,
  output logic [NCH-1:0] cond,
  output logic [NCH-1:0] chg,
  output logic [NCH-1:0] lat
);

  logic [NCH-1:0] sync_s;
  logic [NCH-1:0] prev_q;
  logic [NCH-1:0] lat_q;
  logic [NCH-1:0] lat_d;

  alarm_sync #(
    .W      (NCH),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .d_async (raw),
    .q_sync  (sync_s)
  );

  // Next state: present condition sets; a read clears otherwise.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (sync_s[i]) begin
        lat_d[i] = 1'b1;
      end else if (rd_clr) begin
        lat_d[i] = 1'b0;
      end else begin
        lat_d[i] = lat_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      lat_q  <= '0;
    end else begin
      prev_q <= sync_s;
      lat_q  <= lat_d;
    end
  end

  assign cond = sync_s;
  assign chg  = sync_s ^ prev_q;
  assign lat  = lat_q;

  // R3: a present condition is reflected in its flag one edge later.
  a_r3_cond_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lat_q & $past(sync_s)) == $past(sync_s)));

  // R4: without a read, no flag ever falls.
  a_r4_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_clr |=> ((lat_q & $past(lat_q)) == $past(lat_q)));

  // R4: a read leaves exactly the still-present conditions.
  a_r4_read_leaves_present: assert property (@(posedge clk) disable iff (!rst_n)
    rd_clr |=> (lat_q == $past(sync_s)));

endmodule

// File: rtl/alarm_irq_ctrl.sv
module alarm_irq_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rd_clr,
  output logic pend
);

  logic pend_q;
  logic pend_d;

  always_comb begin
    if (evt) begin
      pend_d = 1'b1;
    end else if (rd_clr) begin
      pend_d = 1'b0;
    end else begin
      pend_d = pend_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
    end else begin
      pend_q <= pend_d;
    end
  end

  assign pend = pend_q;

  // R6 / R5: a qualifying event always leaves the request raised.
  a_r6_event_raises: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> pend_q);

  // R8: the request holds until a read.
  a_r8_hold_until_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !rd_clr) |=> pend_q);

  // R8: a read with no fresh event drops the request.
  a_r8_read_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !evt) |=> !pend_q);

  // R7: the request never rises without an event.
  a_r7_no_spurious_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_q && !evt) |=> !pend_q);

endmodule

// File: rtl/alarm_status_reg.sv
module alarm_status_reg #(
  parameter int NCH         = 7,
  parameter int RED_CH      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] lof_raw,
  input  logic [NCH-1:0] ais_raw,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic [15:0]    host_wdata,
  output logic [15:0]    host_rdata,
  input  logic           reduced_mode,
  input  logic           master_mask,
  output logic           sum_stat,
  output logic           irq_out
);

  import alarm_stat_pkg::*;

  localparam int KN = KINDS;

  logic [KN-1:0][NCH-1:0] raw_all;
  logic [KN-1:0][NCH-1:0] cond_all;
  logic [KN-1:0][NCH-1:0] chg_all;
  logic [KN-1:0][NCH-1:0] lat_all;
  logic [KN-1:0]          ie_q;
  logic [KN-1:0]          ie_d;
  logic [KN-1:0]          kind_evt;
  logic [NCH-1:0]         act;
  logic                   evt;
  logic                   pend;

  assign raw_all[KIND_LOF] = lof_raw;
  assign raw_all[KIND_AIS] = ais_raw;

  // One synchronizing, edge-detecting, sticky bank per alarm kind.
  for (genvar k = 0; k < KN; k++) begin : g_kind
    alarm_latch_bank #(
      .NCH         (NCH),
      .SYNC_STAGES (SYNC_STAGES)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (raw_all[k]),
      .rd_clr (host_rd),
      .cond   (cond_all[k]),
      .chg    (chg_all[k]),
      .lat    (lat_all[k])
    );
  end

  // Channels that carry meaning in the current mode.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      act[i] = !reduced_mode || (i < RED_CH);
    end
  end

  // Enable register with explicit write enable.
  always_comb begin
    ie_d = ie_q;
    if (host_wr) begin
      for (int k = 0; k < KN; k++) begin
        ie_d[k] = host_wdata[ie_pos(k)];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ie_q <= '0;
    end else begin
      ie_q <= ie_d;
    end
  end

  // Qualified change-of-state event.
  always_comb begin
    for (int k = 0; k < KN; k++) begin
      kind_evt[k] = ie_q[k] && (|(chg_all[k] & act));
    end
    evt = master_mask && (|kind_evt);
  end

  alarm_irq_ctrl u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (evt),
    .rd_clr (host_rd),
    .pend   (pend)
  );

  assign sum_stat = pend;
  assign irq_out  = pend;

  // Read-back image.
  always_comb begin
    host_rdata = '0;
    for (int k = 0; k < KN; k++) begin
      for (int i = 0; i < NCH; i++) begin
        host_rdata[flag_pos(k, i)] = lat_all[k][i] && act[i];
      end
      host_rdata[ie_pos(k)] = ie_q[k];
    end
  end

  // R2: a write is visible in the enable bits on the next cycle.
  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    host_wr |=> (host_rdata[7] == $past(host_wdata[7])) &&
                (host_rdata[15] == $past(host_wdata[15])));

  // R9: inactive channels read as zero in reduced mode.
  a_r9_reduced_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    reduced_mode |-> (host_rdata[NCH-1:RED_CH] == '0) &&
                     (host_rdata[HALF_W+NCH-1:HALF_W+RED_CH] == '0));

  // R7: masked register never raises the request from idle.
  a_r7_master_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mask && !irq_out) |=> !irq_out);

endmodule

// File: tb/sim_alarm_status_reg.sv
module sim_alarm_status_reg;

  localparam int PERIOD = 10;
  localparam int NCH    = 7;
  localparam int RED_CH = 4;
  localparam int SYNC   = 2;
  localparam int LAT    = SYNC + 1;

  logic        clk;
  logic        rst_n;
  logic [NCH-1:0] lof_raw;
  logic [NCH-1:0] ais_raw;
  logic        host_wr;
  logic        host_rd;
  logic [15:0] host_wdata;
  logic [15:0] host_rdata;
  logic        reduced_mode;
  logic        master_mask;
  logic        sum_stat;
  logic        irq_out;

  int total;
  int bad;
  bit finished;

  alarm_status_reg #(
    .NCH(NCH), .RED_CH(RED_CH), .SYNC_STAGES(SYNC)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .lof_raw(lof_raw), .ais_raw(ais_raw),
    .host_wr(host_wr), .host_rd(host_rd), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .reduced_mode(reduced_mode),
    .master_mask(master_mask), .sum_stat(sum_stat), .irq_out(irq_out)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic hwrite(input logic [15:0] v);
    host_wr = 1'b1;
    host_wdata = v;
    step(1);
    host_wr = 1'b0;
    host_wdata = '0;
  endtask

  task automatic hread(output logic [15:0] d);
    host_rd = 1'b1;
    #1 d = host_rdata;
    step(1);
    host_rd = 1'b0;
  endtask

  task automatic set_raw(input int kind, input int ch, input logic v);
    if (kind == 0) lof_raw[ch] = v;
    else           ais_raw[ch] = v;
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    total = 0;
    bad = 0;
    finished = 0;
    rst_n = 1'b0;
    lof_raw = '0;
    ais_raw = '0;
    host_wr = 1'b0;
    host_rd = 1'b0;
    host_wdata = '0;
    reduced_mode = 1'b0;
    master_mask = 1'b0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    chk(host_rdata == 16'h0000, "R1 rdata", host_rdata, 0);
    chk(irq_out == 1'b0 && sum_stat == 1'b0, "R1 irq", irq_out, 0);

    // R2: only bits 7 and 15 are stored
    hwrite(16'hFFFF);
    chk(host_rdata == 16'h8080, "R2 all ones", host_rdata, 16'h8080);
    hwrite(16'h0080);
    chk(host_rdata == 16'h0080, "R2 lof enable", host_rdata, 16'h0080);
    hwrite(16'h7F7F);
    chk(host_rdata == 16'h0000, "R2 non enable bits", host_rdata, 0);

    // R3 R4 R6 R7 R8 R9: sweep
    for (int red = 0; red < 2; red++) begin
      for (int msk = 0; msk < 2; msk++) begin
        for (int ies = 0; ies < 3; ies++) begin
          for (int kind = 0; kind < 2; kind++) begin
            for (int ch = 0; ch < NCH; ch++) begin
              logic [15:0] iew;
              logic [15:0] expw;
              bit act;
              bit eirq;
              act = (red == 0) || (ch < RED_CH);
              iew = '0;
              if (ies == 1) iew[kind*8 + 7] = 1'b1;
              if (ies == 2) iew[(1-kind)*8 + 7] = 1'b1;
              expw = iew;
              if (act) expw[kind*8 + ch] = 1'b1;
              eirq = (ies == 1) && (msk == 1) && act;
              reduced_mode = red[0];
              master_mask = msk[0];
              hwrite(iew);
              hread(d);
              chk(irq_out == 1'b0, "R8 idle", irq_out, 0);
              set_raw(kind, ch, 1'b1);
              step(LAT - 1);
              chk(irq_out == 1'b0, "R3 latency early", irq_out, 0);
              step(1);
              chk(host_rdata == expw, "R3 R9 flag rise", host_rdata, expw);
              chk(irq_out == eirq && sum_stat == eirq, "R6 R7 R9 rise", irq_out, eirq);
              step(4);
              chk(irq_out == eirq, "R8 hold", irq_out, eirq);
              hread(d);
              chk(d == expw, "R3 read value", d, expw);
              chk(irq_out == 1'b0, "R8 read clears", irq_out, 0);
              chk(host_rdata == expw, "R4 present stays", host_rdata, expw);
              set_raw(kind, ch, 1'b0);
              step(LAT);
              chk(irq_out == eirq, "R6 R7 R9 fall", irq_out, eirq);
              chk(host_rdata == expw, "R4 held until read", host_rdata, expw);
              hread(d);
              chk(host_rdata == iew, "R4 absent clears", host_rdata, iew);
              chk(irq_out == 1'b0, "R8 read clears fall", irq_out, 0);
            end
          end
        end
      end
    end

    // R5: set wins over a clearing read on the same edge
    reduced_mode = 1'b0;
    master_mask = 1'b1;
    hwrite(16'h8080);
    hread(d);
    ais_raw[2] = 1'b1;
    step(LAT - 1);
    host_rd = 1'b1;
    step(1);
    host_rd = 1'b0;
    chk(host_rdata == 16'h8480, "R5 flag set wins", host_rdata, 16'h8480);
    chk(irq_out == 1'b1, "R5 irq set wins", irq_out, 1);
    ais_raw[2] = 1'b0;
    lof_raw[0] = 1'b1;
    step(LAT - 1);
    host_rd = 1'b1;
    step(1);
    host_rd = 1'b0;
    chk(irq_out == 1'b1, "R5 pending set wins", irq_out, 1);
    chk(host_rdata == 16'h8081, "R5 read with mixed", host_rdata, 16'h8081);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule